// File: doc/BRIEF.md
# Host Control Mailbox Register

This block is the 16-bit control register that both sides of a graphics-processor host interface see. Two parties write it. The local processor is the embedded graphics engine. The host is an external CPU. The wr_host input marks each write as coming from one side or the other. Each byte lane has its own write enable, so a narrow host bus can update one half without disturbing the other.

The high byte carries a halt request and a one-shot non-maskable interrupt trigger. The low byte is a small mailbox with two parts. The first is a pair of 3-bit message fields, one written by each side. The second is a pair of handshake flags that raise interrupts across the interface. Each side may replace only its own message field. Each side may only raise the flag that signals the other side, and may only drop the flag that signals itself. The block drives four signals from this state: the halt line, an immediate self-stop strobe, the NMI pulse, and the two interrupt lines.

Top module: `hctl_mailbox`

## Requirements
- R1: A write with byte enable 1 (bits 15:8) loads bit 15 into the halt request. The halt_o output and read bit 15 show the new value from the cycle after the write edge.
- R2: A write with byte enable 1 and bit 8 set drives nmi_o high for exactly the one cycle after the write edge. Bit 8 always reads back as 0.
- R3: A local write (wr_host=0) with byte enable 0 has three effects. It replaces bits 6:4 (local message). Bit 7 (signal-to-host flag) becomes 1 if the data bit is 1 and is otherwise unchanged. Bit 3 (signal-to-local flag) becomes 0 if the data bit is 0 and is otherwise unchanged. Bits 2:0 are not changed.
- R4: A host write (wr_host=1) with byte enable 0 has three effects. It replaces bits 2:0 (host message). Bit 3 becomes 1 if the data bit is 1 and is otherwise unchanged. Bit 7 becomes 0 if the data bit is 0 and is otherwise unchanged. Bits 6:4 are not changed.
- R5: host_irq_o rises when bit 7 goes from 0 to 1 and falls when it goes from 1 to 0. It changes on the same edge as the register.
- R6: host_int_pend_o rises when bit 3 goes from 0 to 1 and clears when it goes from 1 to 0. It changes on the same edge as the register.
- R7: The high byte changes only when byte enable 1 is set, and the low byte changes only when byte enable 0 is set. A low-only write leaves halt and NMI untouched. A high-only write leaves bits 7:0 untouched.
- R8: Bits 14:9 always read as 0, whatever is written to them.
- R9: stop_now_o is high, combinationally, in any cycle that carries a local write with byte enable 1 and bit 15 set. It is low in every other cycle, host writes included.
- R10: While reset is asserted and just after it is released, rd_data is 0 and halt_o, nmi_o, host_irq_o and host_int_pend_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_host | input | 1 | 1 = host-side write, 0 = local-processor write |
| wr_be | input | 2 | Byte enables: bit 1 = bits 15:8, bit 0 = bits 7:0 |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Current register contents |
| halt_o | output | 1 | Halt request to the local processor |
| stop_now_o | output | 1 | Combinational strobe when the local processor halts itself |
| nmi_o | output | 1 | One-cycle non-maskable interrupt pulse |
| host_irq_o | output | 1 | Interrupt line to the host |
| host_int_pend_o | output | 1 | Host-interrupt pending bit toward the local processor |

## Verification
Results arrive on three schedules. Register fields, halt_o, nmi_o, host_irq_o and host_int_pend_o are due one clock edge after the write that causes them. stop_now_o is due in the same cycle as the write. The bench drives inputs just after each falling edge, so every input holds through the rising edge that captures it. A behavioural reference model updates on each rising edge. All outputs are compared with the model at the following falling edge, and stop_now_o is compared against the inputs that are still held at that point. Directed checks at the byte-lane and handshake corners are sampled one cycle after the write they follow.

// File: rtl/hctl_pkg.sv
package hctl_pkg;

   typedef enum logic {
      SIDE_LOCAL = 1'b0,
      SIDE_HOST  = 1'b1
   } side_e;

   localparam int LANE_BITS = 8;

   // A flag the writer may only raise: a 1 sets it, a 0 leaves it.
   function automatic logic raise_only(input logic cur, input logic din);
      return cur | din;
   endfunction

   // A flag the writer may only drop: a 0 clears it, a 1 leaves it.
   function automatic logic drop_only(input logic cur, input logic din);
      return cur & din;
   endfunction

endpackage

// File: rtl/hctl_hi_lane.sv
module hctl_hi_lane
   import hctl_pkg::*;
#(
   parameter int HALT_OFS = 7,
   parameter int NMI_OFS  = 0,
   parameter int NMI_REG  = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 lane_wr,
   input  side_e                side,
   input  logic [LANE_BITS-1:0] din,
   output logic                 halt_o,
   output logic                 stop_o,
   output logic                 nmi_o,
   output logic [LANE_BITS-1:0] byte_o
);

   localparam logic [LANE_BITS-1:0] USED_MASK =
      LANE_BITS'((1 << HALT_OFS) | (1 << NMI_OFS));

   logic halt_q;
   logic nmi_req;
   logic unused_hi_bits;

   assign unused_hi_bits = ^(din & ~USED_MASK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       halt_q <= 1'b0;
      else if (lane_wr) halt_q <= din[HALT_OFS];
   end

   assign nmi_req = lane_wr & din[NMI_OFS];

   generate
      if (NMI_REG != 0) begin : g_nmi_reg
         logic nmi_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) nmi_q <= 1'b0;
            else        nmi_q <= nmi_req;
         end
         assign nmi_o = nmi_q;
      end else begin : g_nmi_comb
         assign nmi_o = nmi_req;
      end
   endgenerate

   // Local processor halting itself must stop at once: no register here.
   assign stop_o = lane_wr & din[HALT_OFS] & (side == SIDE_LOCAL);
   assign halt_o = halt_q;

   always_comb begin
      byte_o           = '0;
      byte_o[HALT_OFS] = halt_q;
   end

endmodule

// File: rtl/hctl_lo_lane.sv
module hctl_lo_lane
   import hctl_pkg::*;
#(
   parameter int MSG_W = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 lane_wr,
   input  side_e                side,
   input  logic [LANE_BITS-1:0] din,
   output logic [LANE_BITS-1:0] byte_o,
   output logic                 to_host_cur,
   output logic                 to_host_nxt,
   output logic                 to_loc_cur,
   output logic                 to_loc_nxt
);

   localparam int HMSG_LO  = 0;
   localparam int TOLOC_AT = MSG_W;
   localparam int LMSG_LO  = MSG_W + 1;
   localparam int TOHST_AT = 2 * MSG_W + 1;

   logic [MSG_W-1:0] hmsg_q, hmsg_n;
   logic [MSG_W-1:0] lmsg_q, lmsg_n;
   logic             tohst_q, tohst_n;
   logic             toloc_q, toloc_n;

   always_comb begin
      hmsg_n  = hmsg_q;
      lmsg_n  = lmsg_q;
      tohst_n = tohst_q;
      toloc_n = toloc_q;
      if (lane_wr) begin
         if (side == SIDE_HOST) begin
            hmsg_n  = din[HMSG_LO +: MSG_W];
            toloc_n = raise_only(toloc_q, din[TOLOC_AT]);
            tohst_n = drop_only(tohst_q, din[TOHST_AT]);
         end else begin
            lmsg_n  = din[LMSG_LO +: MSG_W];
            tohst_n = raise_only(tohst_q, din[TOHST_AT]);
            toloc_n = drop_only(toloc_q, din[TOLOC_AT]);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hmsg_q  <= '0;
         lmsg_q  <= '0;
         tohst_q <= 1'b0;
         toloc_q <= 1'b0;
      end else begin
         hmsg_q  <= hmsg_n;
         lmsg_q  <= lmsg_n;
         tohst_q <= tohst_n;
         toloc_q <= toloc_n;
      end
   end

   always_comb begin
      byte_o                      = '0;
      byte_o[HMSG_LO +: MSG_W]    = hmsg_q;
      byte_o[TOLOC_AT]            = toloc_q;
      byte_o[LMSG_LO +: MSG_W]    = lmsg_q;
      byte_o[TOHST_AT]            = tohst_q;
   end

   assign to_host_cur = tohst_q;
   assign to_host_nxt = tohst_n;
   assign to_loc_cur  = toloc_q;
   assign to_loc_nxt  = toloc_n;

endmodule

// File: rtl/hctl_flag_track.sv
module hctl_flag_track (
   input  logic clk,
   input  logic rst_n,
   input  logic cur,
   input  logic nxt,
   output logic line_o
);

   logic line_q;

   // Driven by transitions of the stored flag, not by its level.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             line_q <= 1'b0;
      else if (!cur && nxt)   line_q <= 1'b1;
      else if (cur && !nxt)   line_q <= 1'b0;
   end

   assign line_o = line_q;

endmodule

// File: rtl/hctl_mailbox.sv
module hctl_mailbox
   import hctl_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int HALT_BIT = 15,
   parameter int NMI_BIT  = 8,
   parameter int MSG_W    = 3,
   parameter int NMI_REG  = 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic                       wr_host,
   input  logic [DATA_W/LANE_BITS-1:0] wr_be,
   input  logic [DATA_W-1:0]          wr_data,
   output logic [DATA_W-1:0]          rd_data,
   output logic                       halt_o,
   output logic                       stop_now_o,
   output logic                       nmi_o,
   output logic                       host_irq_o,
   output logic                       host_int_pend_o
);

   localparam int LANES    = DATA_W / LANE_BITS;
   localparam int HI_LANE  = LANES - 1;
   localparam int HALT_OFS = HALT_BIT - HI_LANE * LANE_BITS;
   localparam int NMI_OFS  = NMI_BIT - HI_LANE * LANE_BITS;
   localparam int FLAGS    = 2;

   side_e                 side;
   logic [LANES-1:0]      lane_wr;
   logic [LANE_BITS-1:0]  lane_q [LANES];
   logic [FLAGS-1:0]      flag_cur, flag_nxt, flag_line;

   assign side = wr_host ? SIDE_HOST : SIDE_LOCAL;

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         assign lane_wr[i] = wr_en & wr_be[i];
         assign rd_data[i*LANE_BITS +: LANE_BITS] = lane_q[i];
      end
   endgenerate

   hctl_lo_lane #(
      .MSG_W (MSG_W)
   ) u_lo (
      .clk         (clk),
      .rst_n       (rst_n),
      .lane_wr     (lane_wr[0]),
      .side        (side),
      .din         (wr_data[LANE_BITS-1:0]),
      .byte_o      (lane_q[0]),
      .to_host_cur (flag_cur[0]),
      .to_host_nxt (flag_nxt[0]),
      .to_loc_cur  (flag_cur[1]),
      .to_loc_nxt  (flag_nxt[1])
   );

   hctl_hi_lane #(
      .HALT_OFS (HALT_OFS),
      .NMI_OFS  (NMI_OFS),
      .NMI_REG  (NMI_REG)
   ) u_hi (
      .clk     (clk),
      .rst_n   (rst_n),
      .lane_wr (lane_wr[HI_LANE]),
      .side    (side),
      .din     (wr_data[HI_LANE*LANE_BITS +: LANE_BITS]),
      .halt_o  (halt_o),
      .stop_o  (stop_now_o),
      .nmi_o   (nmi_o),
      .byte_o  (lane_q[HI_LANE])
   );

   generate
      for (genvar f = 0; f < FLAGS; f++) begin : g_flag
         hctl_flag_track u_trk (
            .clk    (clk),
            .rst_n  (rst_n),
            .cur    (flag_cur[f]),
            .nxt    (flag_nxt[f]),
            .line_o (flag_line[f])
         );
      end
   endgenerate

   assign host_irq_o      = flag_line[0];
   assign host_int_pend_o = flag_line[1];

endmodule

// File: rtl/hctl_mailbox_chk.sv
module hctl_mailbox_chk #(
   parameter int DATA_W   = 16,
   parameter int HALT_BIT = 15,
   parameter int NMI_BIT  = 8,
   parameter int MSG_W    = 3,
   parameter int NMI_REG  = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              wr_host,
   input logic [1:0]        wr_be,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] rd_data,
   input logic              halt_o,
   input logic              stop_now_o,
   input logic              nmi_o,
   input logic              host_irq_o,
   input logic              host_int_pend_o
);

   initial begin
      assert_two_lanes_R7: assert (DATA_W == 16);
      assert_halt_hi_R1:   assert (HALT_BIT >= 8 && HALT_BIT < DATA_W);
      assert_nmi_hi_R2:    assert (NMI_BIT >= 8 && NMI_BIT < DATA_W && NMI_BIT != HALT_BIT);
      assert_msg_fit_R3:   assert (MSG_W >= 1 && 2 * MSG_W + 2 <= 8);
      assert_nmi_mode_R2:  assert (NMI_REG == 1);
   end

   assert_halt_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_be[1]) |=> (halt_o == $past(wr_data[HALT_BIT])));

   assert_halt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_be[1]) |=> $stable(halt_o));

   assert_low_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_be[0]) |=> $stable(rd_data[7:0]));

   assert_nmi_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_o |-> $past(wr_en && wr_be[1] && wr_data[NMI_BIT]));

   assert_nmi_reads0_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[NMI_BIT]);

   assert_lmsg_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_be[0] && !wr_host) |=> (rd_data[6:4] == $past(wr_data[6:4])));

   assert_hmsg_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_be[0] && wr_host) |=> (rd_data[2:0] == $past(wr_data[2:0])));

   assert_tohost_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_data[7]) |-> $past(wr_en && wr_be[0] && wr_host));

   assert_toloc_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_data[3]) |-> $past(wr_en && wr_be[0] && !wr_host));

   assert_irq_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rd_data[7]) |-> host_irq_o) and ($fell(rd_data[7]) |-> !host_irq_o));

   assert_pend_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rd_data[3]) |-> host_int_pend_o) and ($fell(rd_data[3]) |-> !host_int_pend_o));

   assert_zero_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[14:9] == 6'd0));

   assert_stop_halts_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stop_now_o |=> halt_o);

   assert_stop_local_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stop_now_o |-> !wr_host);

endmodule

bind hctl_mailbox hctl_mailbox_chk #(
   .DATA_W   (DATA_W),
   .HALT_BIT (HALT_BIT),
   .NMI_BIT  (NMI_BIT),
   .MSG_W    (MSG_W),
   .NMI_REG  (NMI_REG)
) u_chk (.*);

// File: tb/hctl_mailbox_tb.sv
module hctl_mailbox_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_host = 1'b0;
   logic [1:0]  wr_be = 2'b00;
   logic [15:0] wr_data = 16'h0000;
   logic [15:0] rd_data;
   logic        halt_o, stop_now_o, nmi_o, host_irq_o, host_int_pend_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hctl_mailbox u_dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .wr_en           (wr_en),
      .wr_host         (wr_host),
      .wr_be           (wr_be),
      .wr_data         (wr_data),
      .rd_data         (rd_data),
      .halt_o          (halt_o),
      .stop_now_o      (stop_now_o),
      .nmi_o           (nmi_o),
      .host_irq_o      (host_irq_o),
      .host_int_pend_o (host_int_pend_o)
   );

   // Behavioural reference model
   bit       m_halt, m_nmi, m_tohost, m_toloc;
   bit [2:0] m_hmsg, m_lmsg;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_halt = 0; m_nmi = 0; m_tohost = 0; m_toloc = 0; m_hmsg = 0; m_lmsg = 0;
      end else begin
         m_nmi = wr_en && wr_be[1] && wr_data[8];
         if (wr_en && wr_be[1]) m_halt = wr_data[15];
         if (wr_en && wr_be[0]) begin
            if (wr_host) begin
               m_hmsg = wr_data[2:0];
               if (wr_data[3])  m_toloc = 1;
               if (!wr_data[7]) m_tohost = 0;
            end else begin
               m_lmsg = wr_data[6:4];
               if (wr_data[7])  m_tohost = 1;
               if (!wr_data[3]) m_toloc = 0;
            end
         end
      end
   end

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act %h exp %h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R1 halt_o", 16'(halt_o), 16'(m_halt));
         check("R1 rd bit15", 16'(rd_data[15]), 16'(m_halt));
         check("R2 nmi_o", 16'(nmi_o), 16'(m_nmi));
         check("R2 rd bit8", 16'(rd_data[8]), 16'd0);
         check("R3 local msg", 16'(rd_data[6:4]), 16'(m_lmsg));
         check("R4 host msg", 16'(rd_data[2:0]), 16'(m_hmsg));
         check("R3 R4 to-host flag", 16'(rd_data[7]), 16'(m_tohost));
         check("R3 R4 to-local flag", 16'(rd_data[3]), 16'(m_toloc));
         check("R5 host_irq_o", 16'(host_irq_o), 16'(m_tohost));
         check("R6 host_int_pend_o", 16'(host_int_pend_o), 16'(m_toloc));
         check("R8 zero bits", 16'(rd_data[14:9]), 16'd0);
         check("R9 stop_now_o", 16'(stop_now_o),
               16'(wr_en && wr_be[1] && wr_data[15] && !wr_host));
      end
   end

   task automatic put(input bit en, input bit host, input logic [1:0] be, input logic [15:0] d);
      @(negedge clk);
      #1;
      wr_en = en; wr_host = host; wr_be = be; wr_data = d;
   endtask

   task automatic idle();
      put(0, 0, 2'b00, 16'h0000);
   endtask

   initial begin
      fork
         begin
            repeat (20000) @(posedge clk);
            if (!done) begin
               errors++;
               $display("FAIL watchdog expired");
               done = 1'b1;
               $display("  CHECKS %0d ERRORS %0d", checks, errors);
               $finish;
            end
         end
      join_none

      repeat (3) @(negedge clk);
      #1;
      check("R10 rd_data in reset", rd_data, 16'h0000);
      check("R10 outputs in reset", 16'({halt_o, nmi_o, host_irq_o, host_int_pend_o}), 16'h0);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check("R10 rd_data after reset", rd_data, 16'h0000);

      // R9 local self-halt is immediate; R1 halt follows one edge later
      put(1, 0, 2'b10, 16'h8000);
      #1;
      check("R9 stop during local halt write", 16'(stop_now_o), 16'd1);
      idle();
      check("R1 halt set", 16'(halt_o), 16'd1);

      // R7 low-only write with bit15=0 leaves halt
      put(1, 1, 2'b01, 16'h0005);
      idle();
      check("R7 halt kept by low-only write", 16'(halt_o), 16'd1);
      check("R4 host msg loaded", 16'(rd_data[2:0]), 16'd5);

      // R9 host halt write gives no stop strobe; R1 halt released
      put(1, 1, 2'b10, 16'h8000);
      #1;
      check("R9 no stop on host write", 16'(stop_now_o), 16'd0);
      put(1, 0, 2'b10, 16'h0000);
      idle();
      check("R1 halt released", 16'(halt_o), 16'd0);

      // R2 NMI pulse lasts exactly one cycle
      put(1, 0, 2'b10, 16'h0100);
      idle();
      check("R2 nmi pulse", 16'(nmi_o), 16'd1);
      idle();
      check("R2 nmi gone", 16'(nmi_o), 16'd0);

      // R7 high-only write leaves the low byte
      put(1, 0, 2'b10, 16'h00FF);
      idle();
      check("R7 low byte kept by high-only write", 16'(rd_data[7:0]), 16'h05);

      // R3 local sets to-host flag and message; R5 irq rises
      put(1, 0, 2'b01, 16'h00B0);
      idle();
      check("R3 local msg and flag", 16'(rd_data[7:4]), 16'hB);
      check("R5 irq raised", 16'(host_irq_o), 16'd1);
      // R4 host writing 1 to bit7 cannot set or clear; writing 0 clears
      put(1, 1, 2'b01, 16'h0080);
      idle();
      check("R4 flag kept by host 1", 16'(host_irq_o), 16'd1);
      put(1, 1, 2'b01, 16'h0008);
      idle();
      check("R5 irq dropped", 16'(host_irq_o), 16'd0);
      check("R6 pend raised", 16'(host_int_pend_o), 16'd1);
      // R3 local writing 1 to bit3 keeps it, writing 0 clears; bit7=0 keeps 0
      put(1, 0, 2'b01, 16'h0008);
      idle();
      check("R3 to-local kept by local 1", 16'(host_int_pend_o), 16'd1);
      put(1, 0, 2'b01, 16'h0000);
      idle();
      check("R6 pend cleared", 16'(host_int_pend_o), 16'd0);
      check("R3 host msg untouched by local", 16'(rd_data[2:0]), 16'd0);

      // R8 writing ones everywhere
      put(1, 1, 2'b11, 16'hFFFF);
      idle();
      check("R8 bits 14:9 stay zero", 16'(rd_data[14:9]), 16'd0);

      // Back-to-back mixed traffic, compared every clock by the model
      for (int i = 0; i < 400; i++) begin
         logic [15:0] d;
         d = 16'($urandom);
         put(1'($urandom), 1'($urandom), 2'($urandom), d);
      end
      idle();
      idle();

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule